// File: doc/BRIEF.md
# Polarity-Aware Current Loop with Totem-Pole Gate Steering

This block closes the inner current loop of a bridgeless boost rectifier once per switching period. At the start of every period it takes a unipolar current-sensor sample, removes the half-scale offset and doubles the result so that the feedback spans the same signed range as the current reference. It then forms the loop error. The sign of the error is chosen by the AC half-cycle flag, because on the negative half-cycle a larger inductor current lowers the sensor reading.

A proportional-integral stage turns the error into a duty value between zero and one. The integrator stops growing in the direction that would push a saturated output further into saturation. The duty value is handed to a counter-based modulator and becomes active only at the counter wrap. The modulated signal and its complement are then steered onto the fast leg of the bridge. One switch of the slow leg is held on and the other held off, with the roles chosen by polarity.

Dropping the enable input turns every switch off on the next clock and clears the integrator. After the enable rises again, the switches stay off for one full period while the first duty value is computed.

Top module: `pfc_current_loop`

## Requirements
- R1: The feedback value is `fb = 2*sense - 2^SW`, where `sense` is an unsigned SW-bit sample and full scale of every signed quantity is 2^SW.
- R2: With `neg_half = 0` (positive half-cycle) the error is `i_ref - fb`.
- R3: With `neg_half = 1` (negative half-cycle) the error is `fb - i_ref`.
- R4: Each update computes `p = floor(kp*err / 2^GSH)`, `step = floor(ki*err / 2^GSH)` and `u = p + integ` using the integrator after its update. The duty is 0 when u < 0, 2^SW when u > 2^SW, and u otherwise.
- R5: The integrator keeps its value instead of adding `step` when the previous update had u > 2^SW and err > 0, or had u < 0 and err < 0.
- R6: The modulator period is 2^CW clocks. In each period the modulated signal is high for the first `duty >> (SW-CW)` counts.
- R7: In the positive half-cycle, `gate_fast_lo` follows the modulated signal, `gate_fast_hi` is its complement, `gate_slow_lo` is on and `gate_slow_hi` is off.
- R8: In the negative half-cycle, `gate_fast_hi` follows the modulated signal, `gate_fast_lo` is its complement, `gate_slow_hi` is on and `gate_slow_lo` is off.
- R9: The inputs are sampled only in the first clock of each period. The resulting duty and polarity take effect at the next counter wrap and hold for the whole following period. Input changes at any other time within a period have no effect.
- R10: While `enable` is low, all four gates are off from the next clock and the integrator and saturation history are cleared. After `enable` rises, the gates stay off for the first full period.
- R11: Under reset, all four gates are off.
- R12: `gate_fast_hi` and `gate_fast_lo` are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run enable; low forces all gates off and clears the integrator |
| i_ref | input | SW+2 | Signed current reference, full scale 2^SW |
| sense | input | SW | Unsigned current-sensor sample |
| neg_half | input | 1 | 1 = negative AC half-cycle |
| kp | input | GW | Unsigned proportional gain, scaled by 2^-GSH |
| ki | input | GW | Unsigned integral gain, scaled by 2^-GSH |
| gate_fast_hi | output | 1 | Fast-leg upper switch |
| gate_fast_lo | output | 1 | Fast-leg lower switch |
| gate_slow_hi | output | 1 | Slow-leg upper switch |
| gate_slow_lo | output | 1 | Slow-leg lower switch |

## Verification
A corrupted integrator or saturation flag never shows at once. It appears as a wrong on-count on the fast-leg gates one period after the update that went wrong, and it keeps showing in every later period until the output leaves saturation. For that reason, integral and anti-windup sequences are compared period by period over many periods. A polarity or steering fault shows within the same period on the slow-leg pair or as swapped fast-leg counts. A duty loaded in mid-period gives an on-count that matches neither the old duty nor the new one. Changing inputs in the middle of each period exposes this in the very window where it happens.

// File: rtl/cl_pkg.sv
`timescale 1ns/1ps
// Shared types for the current-loop block: half-cycle polarity and the
// four-switch gate bundle of the bridge.
package cl_pkg;
    typedef enum logic {
        HALF_POS = 1'b0,
        HALF_NEG = 1'b1
    } half_e;

    typedef struct packed {
        logic fast_hi;
        logic fast_lo;
        logic slow_hi;
        logic slow_lo;
    } gate_t;
endpackage

// File: rtl/cl_error_former.sv
`timescale 1ns/1ps
// Error former: removes the half-scale offset from the sensor sample,
// doubles it, and subtracts it from the reference with a polarity-chosen
// sign. Registers the error and polarity on the period start strobe.
// Assumes: full scale is 2^SW; start is a one-clock strobe.
module cl_error_former
    import cl_pkg::*;
#(
    parameter int SW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 start,
    input  logic signed [SW+1:0] iref,
    input  logic [SW-1:0]        sens,
    input  logic                 neg_half,
    output logic signed [SW+2:0] err_q,
    output logic                 err_v,
    output half_e                pol_q
);
    localparam int EW = SW + 3;

    logic signed [SW+1:0] fb;
    logic signed [EW-1:0] fb_x;
    logic signed [EW-1:0] ir_x;
    logic signed [EW-1:0] err_c;

    // Offset removal and doubling of the unipolar sample.
    always_comb begin
        fb   = $signed({1'b0, sens, 1'b0}) - $signed((SW+2)'(2**SW));
        fb_x = {fb[SW+1], fb};
        ir_x = {iref[SW+1], iref};
        err_c = neg_half ? (fb_x - ir_x) : (ir_x - fb_x);
    end

    // Capture error and polarity once per period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            err_q <= '0;
            err_v <= 1'b0;
            pol_q <= HALF_POS;
        end else begin
            err_v <= start;
            if (start) begin
                err_q <= err_c;
                pol_q <= neg_half ? HALF_NEG : HALF_POS;
            end
        end
    end
endmodule

// File: rtl/cl_pi_comp.sv
`timescale 1ns/1ps
// PI compensator: floor-scaled proportional and integral terms, duty
// clamped to [0, 2^SW], integrator held when it would push a saturated
// output further into saturation. Updates on err_v; cleared when en is low.
// Assumes: gains unsigned, scaled by 2^-GSH.
module cl_pi_comp #(
    parameter int SW  = 12,
    parameter int GW  = 12,
    parameter int GSH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 err_v,
    input  logic signed [SW+2:0] err_in,
    input  logic [GW-1:0]        kp,
    input  logic [GW-1:0]        ki,
    output logic [SW:0]          duty_q
);
    localparam int EW = SW + 3;
    localparam int PW = GW + 1 + EW;
    localparam int IW = PW + 2;
    localparam logic signed [IW-1:0] ONE_W = IW'(2**SW);
    localparam logic [SW:0]          ONE_D = (SW+1)'(2**SW);

    logic signed [PW-1:0] kp_x, ki_x, err_x;
    logic signed [PW-1:0] p_prod, i_prod, p_term, i_term;
    logic signed [IW-1:0] p_ext, i_ext;
    logic signed [IW-1:0] integ, integ_nxt, u;
    logic                 sat_hi, sat_lo;
    logic                 err_pos, err_neg, hold;
    logic                 u_hi, u_lo;
    logic [SW:0]          duty_c;

    // Scaled products with arithmetic (floor) shift.
    always_comb begin
        kp_x   = {{(PW-GW){1'b0}}, kp};
        ki_x   = {{(PW-GW){1'b0}}, ki};
        err_x  = {{(PW-EW){err_in[EW-1]}}, err_in};
        p_prod = kp_x * err_x;
        i_prod = ki_x * err_x;
        p_term = p_prod >>> GSH;
        i_term = i_prod >>> GSH;
        p_ext  = {{(IW-PW){p_term[PW-1]}}, p_term};
        i_ext  = {{(IW-PW){i_term[PW-1]}}, i_term};
    end

    // Directional anti-windup decision and new integrator value.
    always_comb begin
        err_neg   = err_in[EW-1];
        err_pos   = !err_in[EW-1] && (err_in != '0);
        hold      = (sat_hi && err_pos) || (sat_lo && err_neg);
        integ_nxt = hold ? integ : (integ + i_ext);
        u         = p_ext + integ_nxt;
    end

    // Output clamp to the duty range.
    always_comb begin
        u_lo = u[IW-1];
        u_hi = (u > ONE_W);
        if (u_lo)      duty_c = '0;
        else if (u_hi) duty_c = ONE_D;
        else           duty_c = (SW+1)'(u);
    end

    // State update once per period; cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            integ  <= '0;
            sat_hi <= 1'b0;
            sat_lo <= 1'b0;
            duty_q <= '0;
        end else if (err_v) begin
            integ  <= integ_nxt;
            sat_hi <= u_hi;
            sat_lo <= u_lo;
            duty_q <= duty_c;
        end
    end
endmodule

// File: rtl/cl_pwm_timebase.sv
`timescale 1ns/1ps
// PWM time base: free-running period counter while enabled, period-start
// strobe, and shadow-to-active transfer of duty and polarity at the wrap.
// Assumes: SW >= CW; counter held at zero while disabled.
module cl_pwm_timebase
    import cl_pkg::*;
#(
    parameter int SW = 12,
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [SW:0]   duty_in,
    input  half_e         pol_in,
    output logic          start_o,
    output logic [CW-1:0] cnt_o,
    output logic [CW:0]   dact_o,
    output half_e         pol_o,
    output logic          armed_o
);
    localparam int          SHIFT = SW - CW;
    localparam logic [CW-1:0] PMAX = {CW{1'b1}};

    logic [CW:0] dsc;

    // Rescale the duty to counter resolution.
    generate
        if (SHIFT > 0) begin : g_scale
            assign dsc = (CW+1)'(duty_in >> SHIFT);
        end else begin : g_direct
            assign dsc = duty_in;
        end
    endgenerate

    assign start_o = en && (cnt_o == '0);

    // Counter and wrap-aligned loading of the active duty and polarity.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_o   <= '0;
            dact_o  <= '0;
            pol_o   <= HALF_POS;
            armed_o <= 1'b0;
        end else begin
            cnt_o <= cnt_o + 1'b1;
            if (cnt_o == PMAX) begin
                dact_o  <= dsc;
                pol_o   <= pol_in;
                armed_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cl_gate_steer.sv
`timescale 1ns/1ps
// Gate steering: compares counter with active duty and routes the
// modulated signal and its complement to the fast leg, holding one slow-leg
// switch on by polarity. Outputs registered; all off until armed.
// Assumes: dead time is inserted downstream.
module cl_gate_steer
    import cl_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          armed,
    input  logic [CW-1:0] cnt,
    input  logic [CW:0]   dact,
    input  half_e         pol,
    output gate_t         gates_q
);
    logic pwm_on;

    // Modulated signal: high for the first dact counts.
    assign pwm_on = ({1'b0, cnt} < dact);

    // Polarity-dependent routing onto the four switches.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !armed) begin
            gates_q <= '0;
        end else if (pol == HALF_NEG) begin
            gates_q.fast_hi <= pwm_on;
            gates_q.fast_lo <= !pwm_on;
            gates_q.slow_hi <= 1'b1;
            gates_q.slow_lo <= 1'b0;
        end else begin
            gates_q.fast_hi <= !pwm_on;
            gates_q.fast_lo <= pwm_on;
            gates_q.slow_hi <= 1'b0;
            gates_q.slow_lo <= 1'b1;
        end
    end
endmodule

// File: rtl/pfc_current_loop.sv
`timescale 1ns/1ps
// Current loop top: error former -> PI -> PWM time base -> gate steering.
// One loop update per PWM period; new duty active from the next wrap.
// Assumes: SW >= CW >= 2, synchronous active-low reset.
module pfc_current_loop
    import cl_pkg::*;
#(
    parameter int SW  = 12,
    parameter int CW  = 10,
    parameter int GW  = 12,
    parameter int GSH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic signed [SW+1:0] i_ref,
    input  logic [SW-1:0]        sense,
    input  logic                 neg_half,
    input  logic [GW-1:0]        kp,
    input  logic [GW-1:0]        ki,
    output logic                 gate_fast_hi,
    output logic                 gate_fast_lo,
    output logic                 gate_slow_hi,
    output logic                 gate_slow_lo
);
    logic                 start;
    logic signed [SW+2:0] err_q;
    logic                 err_v;
    half_e                pol_smp, pol_act;
    logic [SW:0]          duty_nxt;
    logic [CW-1:0]        pwm_cnt;
    logic [CW:0]          duty_act;
    logic                 armed;
    gate_t                gates;

    cl_error_former #(.SW(SW)) u_err (
        .clk(clk), .rst_n(rst_n), .en(enable), .start(start),
        .iref(i_ref), .sens(sense), .neg_half(neg_half),
        .err_q(err_q), .err_v(err_v), .pol_q(pol_smp)
    );

    cl_pi_comp #(.SW(SW), .GW(GW), .GSH(GSH)) u_pi (
        .clk(clk), .rst_n(rst_n), .en(enable), .err_v(err_v),
        .err_in(err_q), .kp(kp), .ki(ki), .duty_q(duty_nxt)
    );

    cl_pwm_timebase #(.SW(SW), .CW(CW)) u_tb (
        .clk(clk), .rst_n(rst_n), .en(enable),
        .duty_in(duty_nxt), .pol_in(pol_smp),
        .start_o(start), .cnt_o(pwm_cnt), .dact_o(duty_act),
        .pol_o(pol_act), .armed_o(armed)
    );

    cl_gate_steer #(.CW(CW)) u_steer (
        .clk(clk), .rst_n(rst_n), .en(enable), .armed(armed),
        .cnt(pwm_cnt), .dact(duty_act), .pol(pol_act), .gates_q(gates)
    );

    assign gate_fast_hi = gates.fast_hi;
    assign gate_fast_lo = gates.fast_lo;
    assign gate_slow_hi = gates.slow_hi;
    assign gate_slow_lo = gates.slow_lo;
endmodule

// File: rtl/cl_loop_checker.sv
`timescale 1ns/1ps
// Checker for pfc_current_loop: gate exclusivity, steering consistency,
// disable behaviour, duty range and mid-period duty stability.
module cl_loop_checker #(
    parameter int SW = 12,
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          g_fh,
    input logic          g_fl,
    input logic          g_sh,
    input logic          g_sl,
    input logic [SW:0]   duty_nxt,
    input logic [CW-1:0] cnt,
    input logic [CW:0]   dact
);
    localparam logic [SW:0] ONE_D = (SW+1)'(2**SW);

    a_r12_fast_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(g_fh && g_fl));

    a_r7_slow_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({g_sh, g_sl}));

    a_r8_fast_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (g_sh || g_sl) |-> (g_fh != g_fl));

    a_r10_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !(g_fh || g_fl || g_sh || g_sl));

    a_r4_duty_range: assert property (@(posedge clk) disable iff (!rst_n)
        duty_nxt <= ONE_D);

    a_r9_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && (cnt != '0)) |-> $stable(dact));
endmodule

bind pfc_current_loop cl_loop_checker #(.SW(SW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .g_fh(gate_fast_hi), .g_fl(gate_fast_lo),
    .g_sh(gate_slow_hi), .g_sl(gate_slow_lo),
    .duty_nxt(duty_nxt), .cnt(pwm_cnt), .dact(duty_act)
);

// File: tb/pfc_current_loop_test.sv
`timescale 1ns/1ps
// Bench: small configuration (SW=6, CW=4), sweeps and PI sequences with
// an arithmetic model of each period's duty.
module pfc_current_loop_test;
    localparam int SW = 6, CW = 4, GW = 6, GSH = 3;
    localparam int ONE = 64, PER = 16;

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, neg_half = 1'b0;
    logic signed [SW+1:0] i_ref = '0;
    logic [SW-1:0] sense = '0;
    logic [GW-1:0] kp = '0, ki = '0;
    logic g_fh, g_fl, g_sh, g_sl;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int s_iref[0:15], s_sen[0:15], s_pol[0:15];
    int s_len;
    int m_integ;
    bit m_shi, m_slo;

    always #2.5 clk = ~clk;

    pfc_current_loop #(.SW(SW), .CW(CW), .GW(GW), .GSH(GSH)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .i_ref(i_ref),
        .sense(sense), .neg_half(neg_half), .kp(kp), .ki(ki),
        .gate_fast_hi(g_fh), .gate_fast_lo(g_fl),
        .gate_slow_hi(g_sh), .gate_slow_lo(g_sl)
    );

    task automatic check(string tag, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Duty in counter steps for the next sample (R1..R5 arithmetic).
    function automatic int model_step(int k);
        int fb, err, p, st, u, d;
        bit hold;
        fb   = 2 * s_sen[k] - ONE;
        err  = (s_pol[k] != 0) ? (fb - s_iref[k]) : (s_iref[k] - fb);
        p    = (int'(kp) * err) >>> GSH;
        st   = (int'(ki) * err) >>> GSH;
        hold = (m_shi && err > 0) || (m_slo && err < 0);
        if (!hold) m_integ = m_integ + st;
        u = p + m_integ;
        m_shi = (u > ONE);
        m_slo = (u < 0);
        d = (u < 0) ? 0 : ((u > ONE) ? ONE : u);
        return d >> (SW - CW);
    endfunction

    task automatic apply(int k);
        i_ref    = 8'(s_iref[k]);
        sense    = 6'(s_sen[k]);
        neg_half = s_pol[k][0];
    endtask

    task automatic run_seq(string tag);
        int c_fh, c_fl, c_sh, c_sl, c_ov, c_any, dsc;
        @(negedge clk) enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10", "gates while disabled", int'({g_fh, g_fl, g_sh, g_sl}), 0);
        m_integ = 0; m_shi = 0; m_slo = 0;
        apply(0);
        enable = 1'b1;
        c_any = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            c_any += int'(g_fh | g_fl | g_sh | g_sl);
            if (i == 7 && s_len > 1) apply(1);
        end
        check("R10", "gates on in first period", c_any, 0);
        for (int j = 1; j <= s_len; j++) begin
            dsc = model_step(j - 1);
            c_fh = 0; c_fl = 0; c_sh = 0; c_sl = 0; c_ov = 0;
            for (int i = 0; i < PER; i++) begin
                @(negedge clk);
                c_fh += int'(g_fh); c_fl += int'(g_fl);
                c_sh += int'(g_sh); c_sl += int'(g_sl);
                c_ov += int'(g_fh & g_fl);
                if (i == 7 && j + 1 < s_len) apply(j + 1);
            end
            if (s_pol[j-1] != 0) begin
                check({tag, " R3 R8 R6"}, "fast_hi count", c_fh, dsc);
                check({tag, " R3 R8 R6"}, "fast_lo count", c_fl, PER - dsc);
                check({tag, " R8"}, "slow_hi count", c_sh, PER);
                check({tag, " R8"}, "slow_lo count", c_sl, 0);
            end else begin
                check({tag, " R2 R7 R6"}, "fast_lo count", c_fl, dsc);
                check({tag, " R2 R7 R6"}, "fast_hi count", c_fh, PER - dsc);
                check({tag, " R7"}, "slow_lo count", c_sl, PER);
                check({tag, " R7"}, "slow_hi count", c_sh, 0);
            end
            check({tag, " R12"}, "fast overlap", c_ov, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (4) @(negedge clk);
        check("R11", "gates in reset", int'({g_fh, g_fl, g_sh, g_sl}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R11", "gates after reset", int'({g_fh, g_fl, g_sh, g_sl}), 0);

        // R1 sweep: proportional only, gain 1.0
        kp = 6'd8; ki = 6'd0; s_len = 2;
        for (int pol = 0; pol < 2; pol++)
            for (int s = 0; s < 64; s += 9)
                for (int r = 0; r < 5; r++) begin
                    int iv;
                    iv = (r == 0) ? -70 : (r == 1) ? -30 : (r == 2) ? 0 : (r == 3) ? 25 : 60;
                    for (int k = 0; k < 2; k++) begin
                        s_iref[k] = iv; s_sen[k] = s; s_pol[k] = pol;
                    end
                    run_seq("R1");
                end

        // R4: PI sequence, floor rounding on negative error, both halves
        kp = 6'd3; ki = 6'd5; s_len = 10;
        for (int k = 0; k < 10; k++) begin
            s_sen[k]  = (k < 8) ? 32 : 40;
            s_iref[k] = (k < 4) ? 30 : (k < 8) ? -7 : -20;
            s_pol[k]  = (k < 8) ? 0 : 1;
        end
        run_seq("R4");

        // R5: anti-windup, integral only, drive into saturation then reverse
        kp = 6'd0; ki = 6'd63; s_len = 16;
        for (int k = 0; k < 16; k++) begin
            s_sen[k] = 32; s_pol[k] = 0;
            s_iref[k] = (k < 4) ? 100 : -10;
        end
        run_seq("R5");

        // R9/R10: alternating inputs each period, integrator must start clear
        kp = 6'd8; ki = 6'd0; s_len = 6;
        for (int k = 0; k < 6; k++) begin
            s_sen[k] = 32 + k;
            s_iref[k] = k[0] ? 10 : 50;
            s_pol[k] = k[0] ? 1 : 0;
        end
        run_seq("R9 R10");

        @(negedge clk) enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10", "gates after final disable", int'({g_fh, g_fl, g_sh, g_sl}), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule